// File: doc/BRIEF.md
# Resolution-Selectable SAR Bit Register Chain

This block is the digital sequencing core of a successive-approximation converter whose resolution can be chosen per conversion. It is a chain of ten bit cells. A single token travels along the chain, and the cell that holds it is the bit currently being decided. On each comparator-ready strobe the active cell stores the comparator decision for its own position and hands the token on. A start pulse, issued with the sample phase, clears every stored bit and places the token in the first cell.

A two-bit mode code, sampled on the start pulse, picks 10-, 9- or 8-stage operation. The shortened modes route the token around cells in the middle of the chain, just after the first and second cells, not at its tail. The skipped cells stay idle and their result bits read as zero. The reserved fourth code falls back to full resolution and sets an error flag that stays set until reset. A one-cycle end-of-conversion pulse marks the capture of the final cell.

Top module: `sar_bit_chain`

## Requirements
- R1: After synchronous reset, `active_o` is 0, `bits_o` is 0, `eoc_o` is 0 and `mode_err_o` is 0.
- R2: A cycle with `start_i` high clears all of `bits_o` and makes `active_o` equal to 1 (the token is in cell 0) from the next cycle on. `start_i` takes priority over a `strobe_i` in the same cycle.
- R3: On a cycle with `strobe_i` high and `start_i` low, the cell whose `active_o` bit is set copies `dec_i` into the same bit of `bits_o`, and the token moves to the next cell in use. Cycles without `strobe_i`, and strobes while no cell is active, change neither `active_o` nor `bits_o`.
- R4: Mode code `mode_i`=2'b00 uses all ten cells in the order 0,1,...,9.
- R5: Mode code `mode_i`=2'b01 (9-bit) skips cell 2, giving the order 0,1,3,...,9.
- R6: Mode code `mode_i`=2'b10 (8-bit) skips cells 1 and 2, giving the order 0,3,...,9.
- R7: Mode code `mode_i`=2'b11 runs as 2'b00. A start with that code sets `mode_err_o`, which stays high until reset.
- R8: `mode_i` is sampled only in a `start_i` cycle. Changes between starts do not alter the cell order of the conversion in progress.
- R9: A cell skipped by the current mode never shows its `active_o` bit set, and its `bits_o` bit reads 0.
- R10: `eoc_o` is high for exactly one cycle: the cycle after the strobe in which cell 9 captures its decision. At that point `active_o` is 0 and `bits_o[9]` holds the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Resolution code, sampled on start |
| start_i | input | 1 | Sample/start pulse: clears bits and injects the token |
| strobe_i | input | 1 | Comparator-ready strobe |
| dec_i | input | 1 | Comparator decision, taken on a strobe |
| active_o | output | 10 | One-hot token position, cell 0 first |
| bits_o | output | 10 | Stored decision of each cell |
| eoc_o | output | 1 | End-of-conversion pulse |
| mode_err_o | output | 1 | Sticky flag for the reserved mode code |

## Verification
Every result of this block is one register stage away from its cause. The token position, the captured bit and the cleared bits after a start all appear in the cycle after the clock edge that samples `start_i` or `strobe_i`. The end-of-conversion pulse also appears in that cycle, and the error flag in the cycle after the start. The bench drives inputs on the falling edge, lets one rising edge pass and compares at the next falling edge. It then checks that `eoc_o` is low again one cycle later. Idle cycles between strobes, whose length is drawn at random, are checked to leave `active_o` and `bits_o` unchanged.

// File: rtl/sar_chain_pkg.sv
package sar_chain_pkg;

    localparam int unsigned CHAIN_LEN = 10;
    localparam int unsigned GAP_POS   = 1;
    localparam int unsigned MODE_W    = 2;

    typedef enum logic [1:0] {
        RES_FULL  = 2'd0,
        RES_TRIM1 = 2'd1,
        RES_TRIM2 = 2'd2
    } res_e;

    typedef struct packed {
        res_e res;
        logic illegal;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] code);
        mode_dec_t d;
        d.illegal = 1'b0;
        unique case (code)
            2'b00:   d.res = RES_FULL;
            2'b01:   d.res = RES_TRIM1;
            2'b10:   d.res = RES_TRIM2;
            default: begin
                d.res     = RES_FULL;
                d.illegal = 1'b1;
            end
        endcase
        return d;
    endfunction

    function automatic logic cell_used(input res_e r, input int unsigned idx,
                                       input int unsigned gap);
        logic u;
        unique case (r)
            RES_TRIM2: u = !((idx == gap) || (idx == gap + 1));
            RES_TRIM1: u = (idx != gap + 1);
            default:   u = 1'b1;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/sar_mode_ctl.sv
module sar_mode_ctl
    import sar_chain_pkg::*;
#(
    parameter int unsigned N_CELLS = CHAIN_LEN,
    parameter int unsigned GAP     = GAP_POS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    output logic [N_CELLS-1:0]  used_o,
    output logic                err_o
);
    mode_dec_t dec_now;
    res_e      res_q;
    logic      err_q;

    assign dec_now = decode_mode(mode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RES_FULL;
            err_q <= 1'b0;
        end else if (start_i) begin
            res_q <= dec_now.res;
            err_q <= err_q | dec_now.illegal;
        end
    end

    for (genvar k = 0; k < N_CELLS; k++) begin : g_used
        assign used_o[k] = cell_used(res_q, k, GAP);
    end

    assign err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R7
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == 2'b11) |=> err_q); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(used_o)); // R8
    AST_ENDS_USED: assert property (@(posedge clk) disable iff (rst)
        used_o[0] && used_o[N_CELLS-1]); // R4
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell #(
    parameter bit IS_HEAD = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic strobe_i,
    input  logic used_i,
    input  logic hop_i,
    input  logic dec_i,
    output logic tok_o,
    output logic bit_o,
    output logic hop_o
);
    logic tok_q;
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= 1'b0;
            bit_q <= 1'b0;
        end else if (load_i) begin
            tok_q <= IS_HEAD;
            bit_q <= 1'b0;
        end else if (strobe_i) begin
            if (tok_q) begin
                bit_q <= dec_i;
            end
            tok_q <= used_i & hop_i;
        end
    end

    assign tok_o = tok_q;
    assign bit_o = bit_q;
    assign hop_o = tok_q & strobe_i;

    AST_SKIPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !used_i |-> (!tok_q && !bit_q)); // R9
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (tok_q && strobe_i && !load_i) |=> (bit_q == $past(dec_i))); // R3
endmodule

// File: rtl/sar_bit_chain.sv
module sar_bit_chain
    import sar_chain_pkg::*;
#(
    parameter int unsigned N_CELLS = CHAIN_LEN,
    parameter int unsigned GAP     = GAP_POS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               start_i,
    input  logic               strobe_i,
    input  logic               dec_i,
    output logic [N_CELLS-1:0] active_o,
    output logic [N_CELLS-1:0] bits_o,
    output logic               eoc_o,
    output logic               mode_err_o
);
    localparam int unsigned LAST = N_CELLS - 1;

    logic [N_CELLS-1:0] used;
    logic [N_CELLS-1:0] hop;
    logic [N_CELLS-1:0] carry;
    logic               eoc_q;

    sar_mode_ctl #(.N_CELLS(N_CELLS), .GAP(GAP)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (mode_i),
        .used_o  (used),
        .err_o   (mode_err_o)
    );

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        logic hop_in;
        if (k == 0) begin : g_head
            assign hop_in   = 1'b0;
            assign carry[k] = hop[k];
        end else begin : g_body
            assign hop_in   = carry[k-1];
            // a skipped cell forwards the arriving hop unchanged
            assign carry[k] = used[k] ? hop[k] : carry[k-1];
        end

        sar_bit_cell #(.IS_HEAD(k == 0)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .load_i   (start_i),
            .strobe_i (strobe_i),
            .used_i   (used[k]),
            .hop_i    (hop_in),
            .dec_i    (dec_i),
            .tok_o    (active_o[k]),
            .bit_o    (bits_o[k]),
            .hop_o    (hop[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_q <= 1'b0;
        end else begin
            eoc_q <= !start_i && strobe_i && active_o[LAST];
        end
    end

    assign eoc_o = eoc_q;

    AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active_o)); // R3
    AST_START_HEAD: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (active_o == N_CELLS'(1) && bits_o == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !strobe_i) |=> ($stable(active_o) && $stable(bits_o))); // R3
    AST_EOC_PULSE: assert property (@(posedge clk) disable iff (rst)
        eoc_o |=> !eoc_o); // R10
    AST_EOC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> (active_o == '0 && $past(active_o[LAST] && strobe_i))); // R10
endmodule

// File: tb/test_sar_bit_chain.sv
module test_sar_bit_chain;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode_i;
    logic         start_i, strobe_i, dec_i;
    logic [N-1:0] active_o, bits_o;
    logic         eoc_o, mode_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit exp_err = 1'b0;

    always #4 clk = ~clk;

    sar_bit_chain i_sar_bit_chain (
        .clk(clk), .rst(rst), .mode_i(mode_i), .start_i(start_i),
        .strobe_i(strobe_i), .dec_i(dec_i), .active_o(active_o),
        .bits_o(bits_o), .eoc_o(eoc_o), .mode_err_o(mode_err_o)
    );

    function automatic bit used_of(input logic [1:0] m, input int idx);
        if (m == 2'b10) return !(idx == 1 || idx == 2);
        if (m == 2'b01) return idx != 2;
        return 1'b1;
    endfunction

    function automatic int next_of(input logic [1:0] m, input int cur);
        int n = cur + 1;
        while (n < N && !used_of(m, n)) n++;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 0; strobe_i = 0; dec_i = 0; mode_i = 0;
        @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
        chk("R1 active", 32'(active_o), 0);
        chk("R1 bits",   32'(bits_o), 0);
        chk("R1 eoc",    32'(eoc_o), 0);
        chk("R1 err",    32'(mode_err_o), 0);
    endtask

    // one conversion; flip_mode changes mode_i after the start (R8)
    task automatic run_conv(input logic [1:0] m, input bit flip_mode, input bit both);
        logic [N-1:0] eb = '0;
        logic [N-1:0] mask = '0;
        int cur = 0;
        logic [1:0] em = (m == 2'b11) ? 2'b00 : m;
        for (int k = 0; k < N; k++) mask[k] = used_of(em, k);
        @(negedge clk);
        mode_i = m; start_i = 1'b1; strobe_i = both; dec_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; strobe_i = 1'b0;
        if (m == 2'b11) exp_err = 1'b1;
        chk("R2 start token", 32'(active_o), 1);
        chk("R2 start clear", 32'(bits_o), 0);
        chk("R7 err flag", 32'(mode_err_o), 32'(exp_err));
        if (flip_mode) mode_i = 2'(m + 2'd1);
        while (cur < N) begin
            int gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
                dec_i = 1'($urandom);
                @(negedge clk);
                chk("R3 idle active", 32'(active_o), 32'(1 << cur));
                chk("R3 idle bits", 32'(bits_o), 32'(eb));
            end
            dec_i = 1'($urandom);
            strobe_i = 1'b1;
            eb[cur] = dec_i;
            @(negedge clk);
            strobe_i = 1'b0;
            cur = next_of(em, cur);
            if (m == 2'b10)      chk("R6 order", 32'(active_o), (cur < N) ? 32'(1 << cur) : 0);
            else if (m == 2'b01) chk("R5 order", 32'(active_o), (cur < N) ? 32'(1 << cur) : 0);
            else                 chk("R4 order", 32'(active_o), (cur < N) ? 32'(1 << cur) : 0);
            chk("R3 capture", 32'(bits_o), 32'(eb));
            chk("R9 skipped", 32'(bits_o & ~mask), 0);
            if (flip_mode) chk("R8 mode held", 32'(active_o), (cur < N) ? 32'(1 << cur) : 0);
            chk("R10 eoc", 32'(eoc_o), (cur >= N) ? 1 : 0);
        end
        @(negedge clk);
        chk("R10 eoc one cycle", 32'(eoc_o), 0);
        strobe_i = 1'b1; dec_i = ~eb[N-1];
        @(negedge clk);
        strobe_i = 1'b0;
        chk("R3 strobe no token bits", 32'(bits_o), 32'(eb));
        chk("R3 strobe no token active", 32'(active_o), 0);
        chk("R10 no eoc", 32'(eoc_o), 0);
        chk("R7 err sticky", 32'(mode_err_o), 32'(exp_err));
    endtask

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; start_i = 0; strobe_i = 0; dec_i = 0; mode_i = 0;
        repeat (2) @(negedge clk);
        do_reset();
        run_conv(2'b00, 1'b0, 1'b0);
        run_conv(2'b01, 1'b0, 1'b0);
        run_conv(2'b10, 1'b0, 1'b0);
        run_conv(2'b10, 1'b0, 1'b1);
        run_conv(2'b01, 1'b1, 1'b0);
        run_conv(2'b10, 1'b1, 1'b0);
        run_conv(2'b11, 1'b0, 1'b0);
        run_conv(2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) run_conv(2'($urandom), 1'($urandom), 1'($urandom));
        do_reset();
        chk("R7 err cleared by reset", 32'(mode_err_o), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule